// File: doc/BRIEF.md
# Multidimensional Stream Address Generator

This block walks a four-dimensional array (component, horizontal, vertical, temporal) that sits in linear memory and emits one memory address per beat. The result is a one-dimensional stream. Two levels of index counters nest inside each other. The outer level, the tile level, picks where a tile sits. The inner level, the element level, runs through the whole tile for every tile position. Each dimension on each level has its own start offset, iteration count, increment and nesting rank. With these settings, decimated rasters, tiled scans, vertical-first scans and replicated reads need no software loops.

Software writes the parameters, the per-dimension memory strides and a base address through a small write port while the generator is idle, then pulses `start`. Addresses leave on a valid/ready handshake. The first beat of a scan is marked `out_first` and the final beat `out_last`. A one-cycle `done` follows the final beat, and the generator then returns to idle.

Top module: `stream_addr_gen`

## Requirements
- R1: After reset, and at any time while idle, `busy`, `out_valid` and `done` are low. Reset values are count 1, increment 0, offset 0, rank = dimension index, stride 1 and base 0.
- R2: A `start` pulse while idle makes `out_valid` high on the next cycle. That beat carries `out_first` and the address with every index at zero. `out_first` is high on no other beat.
- R3: Each address equals base + Σ over dimensions of stride[d]·(tile_off[d] + elem_off[d] + ti[d]·tile_inc[d] + ei[d]·elem_inc[d]), taken modulo 2^ADDR_W.
- R4: The element level completes all its index combinations before the tile level moves. Within a level, the dimension with the lower rank value counts faster. On equal ranks, the lower dimension index counts faster.
- R5: An increment of zero replicates: the address does not move while that dimension counts, so each value repeats count times.
- R6: Any increment value is accepted, including one equal to the dimension's count (packed traversal). A count of 0 or 1 makes the dimension a single iteration and adds no beats.
- R7: A beat is consumed only when `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_addr`, `out_first` and `out_last` hold.
- R8: `out_last` marks the beat where every counter is at its final value. `done` is high exactly in the cycle after that beat is consumed. On the following cycle `busy` is low.
- R9: While `busy` is high, configuration writes and `start` have no effect on the running scan or on later scans.
- R10: `cfg_sel` = {field[3:0], dim[1:0]}. Field codes: 0 tile count, 1 tile increment, 2 tile offset, 3 tile rank, 4 element count, 5 element increment, 6 element offset, 7 element rank, 8 stride, 9 base (dim ignored). The value is taken from the low bits of `cfg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W (6) | Field and dimension select |
| cfg_wdata | input | ADDR_W (24) | Write value |
| start | input | 1 | Begin a scan when idle |
| busy | output | 1 | Scan in progress or finishing |
| out_valid | output | 1 | Address beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_addr | output | ADDR_W (24) | Linear address |
| out_first | output | 1 | First beat of the scan |
| out_last | output | 1 | Final beat of the scan |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The bench builds the block with its defaults: four dimensions, 10-bit counts and increments, 16-bit strides and 24-bit addresses. This width lets a base near the top of the address space wrap back to a small address, and it lets 256-beat tiled scans run. The scans cover:
- a decimated raster;
- an 8x8 tiled frame, with and without disturbance;
- a vertical-first scan;
- colour and temporal replication;
- packed strides with tied ranks and a zero count;
- a single-beat scan.

The back-pressure pattern varies between scans. The disturbed tiled run issues writes and a start mid-scan, then repeats the same scan to show that the configuration survived.

// File: rtl/sag_pkg.sv
package sag_pkg;

   typedef enum logic [3:0] {
      FLD_TCNT   = 4'd0,
      FLD_TINC   = 4'd1,
      FLD_TOFF   = 4'd2,
      FLD_TRANK  = 4'd3,
      FLD_ECNT   = 4'd4,
      FLD_EINC   = 4'd5,
      FLD_EOFF   = 4'd6,
      FLD_ERANK  = 4'd7,
      FLD_STRIDE = 4'd8,
      FLD_BASE   = 4'd9
   } cfg_field_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } scan_state_e;

   localparam int FIELD_W = 4;

   function automatic int sel_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sag_cfg_regs.sv
module sag_cfg_regs
   import sag_pkg::*;
#(
   parameter int NDIM     = 4,
   parameter int IDX_W    = 10,
   parameter int STRIDE_W = 16,
   parameter int ADDR_W   = 24,
   parameter int DIM_W    = 2,
   parameter int ORD_W    = 2,
   parameter int SEL_W    = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [SEL_W-1:0]               sel,
   input  logic [ADDR_W-1:0]              wdata,
   output logic [NDIM-1:0][IDX_W-1:0]     t_cnt,
   output logic [NDIM-1:0][IDX_W-1:0]     t_inc,
   output logic [NDIM-1:0][IDX_W-1:0]     t_off,
   output logic [NDIM-1:0][ORD_W-1:0]     t_rank,
   output logic [NDIM-1:0][IDX_W-1:0]     e_cnt,
   output logic [NDIM-1:0][IDX_W-1:0]     e_inc,
   output logic [NDIM-1:0][IDX_W-1:0]     e_off,
   output logic [NDIM-1:0][ORD_W-1:0]     e_rank,
   output logic [NDIM-1:0][STRIDE_W-1:0]  stride,
   output logic [ADDR_W-1:0]              base
);

   cfg_field_e        fld;
   logic [DIM_W-1:0]  dsel;
   logic [IDX_W-1:0]  v_idx;
   logic [ORD_W-1:0]  v_ord;
   logic [STRIDE_W-1:0] v_str;

   assign fld   = cfg_field_e'(sel[SEL_W-1:DIM_W]);
   assign dsel  = sel[DIM_W-1:0];
   assign v_idx = wdata[IDX_W-1:0];
   assign v_ord = wdata[ORD_W-1:0];
   assign v_str = wdata[STRIDE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int d = 0; d < NDIM; d++) begin
            t_cnt[d]  <= IDX_W'(1);
            t_inc[d]  <= '0;
            t_off[d]  <= '0;
            t_rank[d] <= ORD_W'(d);
            e_cnt[d]  <= IDX_W'(1);
            e_inc[d]  <= '0;
            e_off[d]  <= '0;
            e_rank[d] <= ORD_W'(d);
            stride[d] <= STRIDE_W'(1);
         end
      end else if (wr_en) begin
         for (int d = 0; d < NDIM; d++) begin
            if (dsel == DIM_W'(d)) begin
               case (fld)
                  FLD_TCNT:   t_cnt[d]  <= v_idx;
                  FLD_TINC:   t_inc[d]  <= v_idx;
                  FLD_TOFF:   t_off[d]  <= v_idx;
                  FLD_TRANK:  t_rank[d] <= v_ord;
                  FLD_ECNT:   e_cnt[d]  <= v_idx;
                  FLD_EINC:   e_inc[d]  <= v_idx;
                  FLD_EOFF:   e_off[d]  <= v_idx;
                  FLD_ERANK:  e_rank[d] <= v_ord;
                  FLD_STRIDE: stride[d] <= v_str;
                  default: ;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base <= '0;
      else if (wr_en && fld == FLD_BASE)
         base <= wdata;
   end

endmodule

// File: rtl/sag_odometer.sv
module sag_odometer #(
   parameter int NDIM  = 4,
   parameter int IDX_W = 10,
   parameter int ORD_W = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear,
   input  logic                        adv,
   input  logic [NDIM-1:0][IDX_W-1:0]  cnt,
   input  logic [NDIM-1:0][ORD_W-1:0]  rank,
   output logic [NDIM-1:0][IDX_W-1:0]  idx,
   output logic                        all_term
);

   logic [NDIM-1:0][IDX_W-1:0] last_idx;
   logic [NDIM-1:0]            term;
   logic [NDIM-1:0]            carry;

   // final index per dimension; a count of zero behaves as one
   for (genvar d = 0; d < NDIM; d++) begin : g_term
      assign last_idx[d] = (cnt[d] == '0) ? '0 : cnt[d] - IDX_W'(1);
      assign term[d]     = (idx[d] == last_idx[d]);
   end

   // a dimension steps when every faster-counting dimension is at its end
   always_comb begin
      carry = '1;
      for (int d = 0; d < NDIM; d++) begin
         for (int e = 0; e < NDIM; e++) begin
            if (e != d && ((rank[e] < rank[d]) || (rank[e] == rank[d] && e < d)))
               carry[d] = carry[d] & term[e];
         end
      end
   end

   assign all_term = &term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clear) begin
         idx <= '0;
      end else if (adv) begin
         for (int d = 0; d < NDIM; d++) begin
            if (carry[d])
               idx[d] <= term[d] ? '0 : idx[d] + IDX_W'(1);
         end
      end
   end

endmodule

// File: rtl/sag_addr_calc.sv
module sag_addr_calc #(
   parameter int NDIM     = 4,
   parameter int IDX_W    = 10,
   parameter int STRIDE_W = 16,
   parameter int ADDR_W   = 24
) (
   input  logic [ADDR_W-1:0]              base,
   input  logic [NDIM-1:0][STRIDE_W-1:0]  stride,
   input  logic [NDIM-1:0][IDX_W-1:0]     t_off,
   input  logic [NDIM-1:0][IDX_W-1:0]     e_off,
   input  logic [NDIM-1:0][IDX_W-1:0]     t_inc,
   input  logic [NDIM-1:0][IDX_W-1:0]     e_inc,
   input  logic [NDIM-1:0][IDX_W-1:0]     t_idx,
   input  logic [NDIM-1:0][IDX_W-1:0]     e_idx,
   output logic [ADDR_W-1:0]              addr
);

   logic [ADDR_W-1:0] part [NDIM];

   for (genvar d = 0; d < NDIM; d++) begin : g_dim
      logic [ADDR_W-1:0] pos;
      assign pos = ADDR_W'(t_off[d]) + ADDR_W'(e_off[d])
                 + ADDR_W'(t_idx[d]) * ADDR_W'(t_inc[d])
                 + ADDR_W'(e_idx[d]) * ADDR_W'(e_inc[d]);
      assign part[d] = pos * ADDR_W'(stride[d]);
   end

   always_comb begin
      addr = base;
      for (int d = 0; d < NDIM; d++)
         addr = addr + part[d];
   end

endmodule

// File: rtl/stream_addr_gen.sv
module stream_addr_gen
   import sag_pkg::*;
#(
   parameter int NDIM     = 4,
   parameter int IDX_W    = 10,
   parameter int STRIDE_W = 16,
   parameter int ADDR_W   = 24,
   localparam int DIM_W   = sel_bits(NDIM),
   localparam int ORD_W   = DIM_W,
   localparam int SEL_W   = FIELD_W + DIM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              start,
   output logic              busy,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_first,
   output logic              out_last,
   output logic              done
);

   if (NDIM < 1 || NDIM > 8) begin : g_bad_ndim
      $error("stream_addr_gen: NDIM must be 1..8");
   end
   if (IDX_W < 2) begin : g_bad_idx
      $error("stream_addr_gen: IDX_W must be at least 2");
   end
   if (ADDR_W < IDX_W || ADDR_W < STRIDE_W) begin : g_bad_addr
      $error("stream_addr_gen: ADDR_W must cover IDX_W and STRIDE_W");
   end

   logic [NDIM-1:0][IDX_W-1:0]    t_cnt, t_inc, t_off, e_cnt, e_inc, e_off;
   logic [NDIM-1:0][ORD_W-1:0]    t_rank, e_rank;
   logic [NDIM-1:0][STRIDE_W-1:0] stride;
   logic [ADDR_W-1:0]             base;
   logic [NDIM-1:0][IDX_W-1:0]    t_idx, e_idx;
   logic                          t_all, e_all;

   scan_state_e st;
   logic        first_q;
   logic        launch, fire, final_beat;

   assign launch     = (st == ST_IDLE) && start;
   assign fire       = out_valid && out_ready;
   assign final_beat = t_all && e_all;

   sag_cfg_regs #(
      .NDIM(NDIM), .IDX_W(IDX_W), .STRIDE_W(STRIDE_W), .ADDR_W(ADDR_W),
      .DIM_W(DIM_W), .ORD_W(ORD_W), .SEL_W(SEL_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we && (st == ST_IDLE)),
      .sel    (cfg_sel),
      .wdata  (cfg_wdata),
      .t_cnt  (t_cnt),
      .t_inc  (t_inc),
      .t_off  (t_off),
      .t_rank (t_rank),
      .e_cnt  (e_cnt),
      .e_inc  (e_inc),
      .e_off  (e_off),
      .e_rank (e_rank),
      .stride (stride),
      .base   (base)
   );

   sag_odometer #(.NDIM(NDIM), .IDX_W(IDX_W), .ORD_W(ORD_W)) u_elem (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (launch),
      .adv      (fire && !final_beat),
      .cnt      (e_cnt),
      .rank     (e_rank),
      .idx      (e_idx),
      .all_term (e_all)
   );

   sag_odometer #(.NDIM(NDIM), .IDX_W(IDX_W), .ORD_W(ORD_W)) u_tile (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (launch),
      .adv      (fire && e_all && !final_beat),
      .cnt      (t_cnt),
      .rank     (t_rank),
      .idx      (t_idx),
      .all_term (t_all)
   );

   sag_addr_calc #(
      .NDIM(NDIM), .IDX_W(IDX_W), .STRIDE_W(STRIDE_W), .ADDR_W(ADDR_W)
   ) u_addr (
      .base   (base),
      .stride (stride),
      .t_off  (t_off),
      .e_off  (e_off),
      .t_inc  (t_inc),
      .e_inc  (e_inc),
      .t_idx  (t_idx),
      .e_idx  (e_idx),
      .addr   (out_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         first_q <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               st      <= ST_RUN;
               first_q <= 1'b1;
            end
            ST_RUN: if (fire) begin
               first_q <= 1'b0;
               if (final_beat) st <= ST_FIN;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign out_valid = (st == ST_RUN);
   assign out_first = out_valid && first_q;
   assign out_last  = out_valid && final_beat;
   assign done      = (st == ST_FIN);

endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ADDR_W-1:0] out_addr,
   input logic              out_first,
   input logic              out_last,
   input logic              done
);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!out_valid && !done));

   a_r2_start_first: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (out_valid && out_first));

   a_r2_first_once: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> !out_first);

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_addr) && $stable(out_first) && $stable(out_last)));

   a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> (done && !out_valid));

   a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

endmodule

bind stream_addr_gen sag_checker #(.ADDR_W(ADDR_W)) u_sag_checker (.*);

// File: tb/stream_addr_gen_bench.sv
module stream_addr_gen_bench;

   localparam int NDIM = 4, IDX_W = 10, STRIDE_W = 16, ADDR_W = 24;
   localparam int DIM_W = 2, SEL_W = 6;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, cfg_we = 1'b0, start = 1'b0, out_ready = 1'b0;
   logic [SEL_W-1:0]  cfg_sel = '0;
   logic [ADDR_W-1:0] cfg_wdata = '0;
   logic busy, out_valid, out_first, out_last, done;
   logic [ADDR_W-1:0] out_addr;

   stream_addr_gen u_stream_addr_gen (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .start(start), .busy(busy),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
      .out_first(out_first), .out_last(out_last), .done(done)
   );

   int n_vec = 0, n_bad = 0, cyc = 0;
   int sh_cnt[2][4], sh_inc[2][4], sh_off[2][4], sh_rank[2][4], sh_stride[4];
   longint sh_base;
   logic [ADDR_W-1:0] q_addr[$];
   bit q_first[$], q_last[$];
   bit mon_en = 0, exp_done = 0, got_done = 0;
   int ready_pct = 100;
   string cur_req = "R3";

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish");
         summary();
         $finish;
      end
   end

   // per-cycle monitor against the expected queue
   always @(negedge clk) begin
      if (mon_en) begin
         out_ready = ($urandom_range(99) < ready_pct);
         if (exp_done) begin
            check(done == 1'b1, "R8", "done pulse after last", done, 1);
            exp_done = 0;
            got_done = 1;
         end else if (done) begin
            check(1'b0, "R8", "unexpected done", 1, 0);
         end
         if (out_valid) begin
            if (q_addr.size() == 0) begin
               check(1'b0, "R8", "beat beyond end of scan", out_addr, 0);
            end else begin
               check(out_addr == q_addr[0], cur_req, "address", out_addr, q_addr[0]);
               check(out_first == q_first[0], "R2", "first flag", out_first, q_first[0]);
               check(out_last == q_last[0], "R8", "last flag", out_last, q_last[0]);
               if (out_ready) begin
                  if (q_last[0]) exp_done = 1;
                  void'(q_addr.pop_front());
                  void'(q_first.pop_front());
                  void'(q_last.pop_front());
               end
            end
         end
      end
   end

   task automatic cfg_wr(int fld, int dim, longint val);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_sel   = {4'(fld), 2'(dim)};
      cfg_wdata = ADDR_W'(val);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   // lvl 0 = tile level (fields 0..3), lvl 1 = element level (fields 4..7), per R10
   task automatic set_dim(int lvl, int d, int cnt, int inc, int off, int rank);
      cfg_wr(lvl*4 + 0, d, cnt);
      cfg_wr(lvl*4 + 1, d, inc);
      cfg_wr(lvl*4 + 2, d, off);
      cfg_wr(lvl*4 + 3, d, rank);
      sh_cnt[lvl][d] = cnt; sh_inc[lvl][d] = inc;
      sh_off[lvl][d] = off; sh_rank[lvl][d] = rank;
   endtask

   task automatic set_stride(int d, int v);
      cfg_wr(8, d, v);
      sh_stride[d] = v;
   endtask

   task automatic set_base(longint v);
      cfg_wr(9, 0, v);
      sh_base = v;
   endtask

   task automatic clean_cfg();
      for (int l = 0; l < 2; l++)
         for (int d = 0; d < NDIM; d++)
            set_dim(l, d, 1, 0, 0, d);
      for (int d = 0; d < NDIM; d++) set_stride(d, 1);
      set_base(0);
   endtask

   // behavioural model: mixed-radix decomposition of a linear beat count
   task automatic build_expected();
      int perm[2][4];
      int n[2];
      int ti[4], ei[4];
      q_addr.delete(); q_first.delete(); q_last.delete();
      for (int l = 0; l < 2; l++) begin
         bit used[4];
         n[l] = 1;
         for (int d = 0; d < NDIM; d++) begin
            used[d] = 0;
            n[l] *= (sh_cnt[l][d] == 0) ? 1 : sh_cnt[l][d];
         end
         for (int p = 0; p < NDIM; p++) begin
            int best = -1;
            for (int d = 0; d < NDIM; d++)
               if (!used[d] && (best < 0 ||
                   sh_rank[l][d]*8 + d < sh_rank[l][best]*8 + best))
                  best = d;
            used[best] = 1;
            perm[l][p] = best;
         end
      end
      for (int kt = 0; kt < n[0]; kt++) begin
         int r = kt;
         for (int p = 0; p < NDIM; p++) begin
            int d = perm[0][p];
            int c = (sh_cnt[0][d] == 0) ? 1 : sh_cnt[0][d];
            ti[d] = r % c; r = r / c;
         end
         for (int ke = 0; ke < n[1]; ke++) begin
            longint s = sh_base;
            int r2 = ke;
            for (int p = 0; p < NDIM; p++) begin
               int d = perm[1][p];
               int c = (sh_cnt[1][d] == 0) ? 1 : sh_cnt[1][d];
               ei[d] = r2 % c; r2 = r2 / c;
            end
            for (int d = 0; d < NDIM; d++)
               s += longint'(sh_stride[d]) * (sh_off[0][d] + sh_off[1][d]
                    + ti[d]*sh_inc[0][d] + ei[d]*sh_inc[1][d]);
            q_addr.push_back(ADDR_W'(s));
            q_first.push_back(kt == 0 && ke == 0);
            q_last.push_back(kt == n[0]-1 && ke == n[1]-1);
         end
      end
   endtask

   task automatic run_scan(string req, int pct, bit disturb);
      int beats;
      build_expected();
      beats = q_addr.size();
      cur_req = req;
      ready_pct = pct;
      got_done = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (disturb) begin
         // R9: write and restart mid-scan, both must be ignored
         repeat (6) @(negedge clk);
         cfg_we = 1'b1; cfg_sel = {4'd0, 2'd1}; cfg_wdata = 24'd1; start = 1'b1;
         @(negedge clk);
         cfg_we = 1'b0; start = 1'b0;
      end
      while (!got_done) @(posedge clk);
      @(negedge clk);
      check(busy == 1'b0, "R8", "idle after done", busy, 0);
      check(q_addr.size() == 0, req, "all beats delivered", q_addr.size(), 0);
      $display("scan %s: %0d beats", req, beats);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 0, "R1", "busy after reset", busy, 0);
      check(out_valid == 0, "R1", "valid after reset", out_valid, 0);
      check(done == 0, "R1", "done after reset", done, 0);
      mon_en = 1;

      // R1: reset values give a single beat at address 0
      sh_base = 0;
      for (int l = 0; l < 2; l++)
         for (int d = 0; d < NDIM; d++) begin
            sh_cnt[l][d] = 1; sh_inc[l][d] = 0; sh_off[l][d] = 0; sh_rank[l][d] = d;
         end
      for (int d = 0; d < NDIM; d++) sh_stride[d] = 1;
      run_scan("R1", 100, 0);

      // decimated raster, 8x4 frame, every second pixel (R3 R10 R2)
      clean_cfg();
      set_dim(0, 1, 4, 2, 0, 1);
      set_dim(0, 2, 4, 1, 0, 2);
      set_stride(2, 8); set_stride(3, 32);
      set_base(24'h100);
      run_scan("R3", 100, 0);

      // vertical-first variant (R4)
      set_dim(0, 1, 4, 2, 0, 2);
      set_dim(0, 2, 4, 1, 0, 1);
      run_scan("R4", 80, 0);

      // 8x8 tiles of a 16x16 frame, disturbed then repeated (R4 R9 R7)
      clean_cfg();
      set_dim(0, 1, 2, 8, 0, 1);
      set_dim(0, 2, 2, 8, 0, 2);
      set_dim(1, 1, 8, 1, 0, 1);
      set_dim(1, 2, 8, 1, 0, 2);
      set_stride(2, 16); set_stride(3, 256);
      run_scan("R9", 70, 1);
      run_scan("R7", 40, 0);

      // colour components, temporal replication, offsets (R5 R3)
      clean_cfg();
      set_dim(1, 0, 3, 1, 0, 0);
      set_dim(0, 1, 4, 1, 1, 1);
      set_dim(0, 3, 2, 0, 0, 3);
      set_dim(1, 2, 1, 0, 2, 2);
      set_stride(1, 3); set_stride(2, 12); set_stride(3, 64);
      set_base(24'h40);
      run_scan("R5", 60, 0);

      // packed increment equal to count, tied ranks, zero count (R6 R4)
      clean_cfg();
      set_dim(1, 1, 4, 1, 0, 1);
      set_dim(0, 1, 4, 4, 0, 0);
      set_dim(0, 2, 2, 1, 0, 0);
      set_dim(0, 0, 1, 0, 0, 0);
      set_dim(0, 3, 0, 5, 0, 0);
      set_stride(2, 16); set_stride(3, 0);
      run_scan("R6", 90, 0);

      // single-beat scan with address wrap (R3 R8 R2)
      clean_cfg();
      set_dim(0, 1, 1, 0, 32, 1);
      set_base(24'hFFFFF0);
      run_scan("R8", 100, 0);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end

endmodule